// File: doc/BRIEF.md
# Software Reset Line Register

This block holds a bank of active-low reset lines, one per on-chip subsystem, in a single register on a simple register bus. Each stored bit drives its reset output directly: a 0 keeps the subsystem in reset and a 1 lets it run. Software asserts or releases any line by read-modify-write of the whole word. A reset pulse is made with two back-to-back writes, first clearing the bit and then setting it. There is no self-timed pulse logic, so the line stays low for exactly the cycles between the two writes.

A power-domain sequencer has a side port with two masks. One mask forces lines into reset and the other releases them. The masks act in the same clock edge as any bus write and are merged on top of the written data. The register sits at byte offset 0x30 of its control window. Read data comes back combinationally for that offset. Every other offset reads as zero and ignores writes.

Top module: `swrst_reg`

## Requirements
- R1: After power-on reset (rstN low), every stored bit is 0, so every reset output is 0 (all subsystems held in reset) and a read at offset 0x30 returns 0.
- R2: Each reset output equals its stored bit. A stored 0 holds the subsystem in reset and a stored 1 releases it, with no extra register between storage and output.
- R3: While busAddr equals 0x30, busRdData returns the exact stored word in the same cycle (combinationally), bit for bit.
- R4: A bus write (busWrEn high, busAddr 0x30) with both sequencer masks zero replaces all stored bits with busWrData at the next rising clock edge.
- R5: A bus write to any address other than 0x30 changes no stored bit. A read at any other address returns 0.
- R6: Writing a bit to 0 and then back to 1 produces a reset pulse on that line only. The line is low from the edge of the first write until the edge of the second, and all other lines keep their values.
- R7: A bit set in seqClrMask forces that stored bit to 0 at the next rising edge. Bits not in either mask keep their values (or take the write data if a bus write is present).
- R8: A bit set in seqSetMask forces that stored bit to 1 at the next rising edge, unless the same bit is also set in seqClrMask.
- R9: When a bus write and sequencer masks occur in the same cycle, the next value is ((write data) OR seqSetMask) AND NOT seqClrMask. Clear wins over set and over the write data.
- R10: With no bus write to 0x30 and both masks zero, the stored word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| busAddr | input | 8 | Byte address within the control window |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| seqClrMask | input | 32 | Sequencer request: put masked lines into reset |
| seqSetMask | input | 32 | Sequencer request: release masked lines |
| subsysRstN | output | 32 | Active-low reset outputs, one per subsystem |

## Verification
The bench builds the block with its default parameters: 32 lines, an 8-bit address and the register at offset 0x30. These defaults make the top bit, the bottom bit and neighbouring offsets such as 0x2C and 0x34 directly reachable. The bench checks offset misses, pulses on edge bits, and masks that overlap each other and the write data in the same cycle. Every cycle is compared, so the exact length of a pulse is checked as well as its end value.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  // Strobes from address decode to the storage datapath
  typedef struct packed {
    logic wrHit;   // write accepted at the register offset
    logic rdHit;   // read address selects the register
  } rstStrobe_t;

endpackage

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_OFFS = 'h30
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output rstStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFS);

  logic addrHit;

  always_comb begin
    addrHit       = (busAddr == OFFS);
    strobe.rdHit  = addrHit;
    strobe.wrHit  = addrHit && busWrEn;
  end

  // R5: a write strobe never leaves the decoder for a foreign address
  always_comb begin
    a_r5_wr_decode: assert (!(strobe.wrHit && (busAddr != OFFS)));
  end

endmodule

// File: rtl/swrst_dp.sv
module swrst_dp
  import swrst_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  rstStrobe_t         strobe,
  input  logic [N_LINES-1:0] wrData,
  input  logic [N_LINES-1:0] clrMask,
  input  logic [N_LINES-1:0] setMask,
  output logic [N_LINES-1:0] lines,
  output logic [N_LINES-1:0] rdData
);

  // One storage cell per reset line
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic baseBit;
    logic nextBit;
    logic cellQ;

    always_comb begin
      baseBit = strobe.wrHit ? wrData[i] : cellQ;
      nextBit = (baseBit | setMask[i]) & ~clrMask[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cellQ <= 1'b0;
      else       cellQ <= nextBit;
    end

    assign lines[i] = cellQ;
  end

  assign rdData = strobe.rdHit ? lines : '0;

  // R7 / R9: cleared lines are 0 after the edge
  a_r7_clr_forces_low: assert property (@(posedge clk) disable iff (!rstN)
    (clrMask != '0) |=> ((lines & $past(clrMask)) == '0));

  // R8: set-only lines are 1 after the edge
  a_r8_set_forces_high: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((lines & $past(setMask & ~clrMask)) == $past(setMask & ~clrMask)));

  // R4: plain write loads the data word
  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHit && clrMask == '0 && setMask == '0) |=> (lines == $past(wrData)));

  // R10: idle cycle keeps the word
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrHit && clrMask == '0 && setMask == '0) |=> $stable(lines));

endmodule

// File: rtl/swrst_reg.sv
module swrst_reg
  import swrst_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int N_LINES  = 32,
  parameter int REG_OFFS = 'h30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [N_LINES-1:0] busWrData,
  output logic [N_LINES-1:0] busRdData,
  input  logic [N_LINES-1:0] seqClrMask,
  input  logic [N_LINES-1:0] seqSetMask,
  output logic [N_LINES-1:0] subsysRstN
);

  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFS);

  rstStrobe_t strobe;

  swrst_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_OFFS(REG_OFFS)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  swrst_dp #(
    .N_LINES(N_LINES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWrData),
    .clrMask(seqClrMask),
    .setMask(seqSetMask),
    .lines  (subsysRstN),
    .rdData (busRdData)
  );

  // R3: a read at the offset shows exactly what drives the outputs
  a_r3_read_matches: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFFS) |-> (busRdData == subsysRstN));

  // R5: any other offset reads as zero
  a_r5_miss_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != OFFS) |-> (busRdData == '0));

endmodule

// File: tb/swrst_reg_tb.sv
module swrst_reg_tb;

  localparam int AW = 8;
  localparam int NL = 32;
  localparam logic [AW-1:0] OFFS = 8'h30;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [NL-1:0] busWrData = '0;
  logic [NL-1:0] busRdData;
  logic [NL-1:0] seqClrMask = '0;
  logic [NL-1:0] seqSetMask = '0;
  logic [NL-1:0] subsysRstN;

  int checks = 0;
  int errors = 0;
  logic [NL-1:0] model = '0;
  bit done = 1'b0;

  typedef struct {
    logic [NL-1:0] expLines;
    logic [NL-1:0] expRd;
    string         tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz

  swrst_reg u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .seqClrMask(seqClrMask),
    .seqSetMask(seqSetMask), .subsysRstN(subsysRstN)
  );

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic [AW-1:0] a, input logic we, input logic [NL-1:0] wd,
                      input logic [NL-1:0] clr, input logic [NL-1:0] set, input string tag);
    item_t it;
    logic [NL-1:0] base;
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = wd; seqClrMask = clr; seqSetMask = set;
    base  = (we && a == OFFS) ? wd : model;
    model = (base | set) & ~clr;
    it.expLines = model;
    it.expRd    = (a == OFFS) ? model : '0;
    it.tag      = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (subsysRstN !== it.expLines || busRdData !== it.expRd) begin
        errors++;
        $display("FAIL %s: lines=%h rd=%h expected lines=%h rd=%h",
                 it.tag, subsysRstN, busRdData, it.expLines, it.expRd);
      end
    end
  end

  task automatic chk(input logic [NL-1:0] act, input logic [NL-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        #5;
        busAddr = OFFS;
        #1;
        chk(subsysRstN, '0, "R1 outputs in reset");
        chk(busRdData,  '0, "R1 read in reset");
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        // R1 / R10: idle after reset keeps zero
        step(OFFS, 0, '0, '0, '0, "R1");
        step(OFFS, 0, '0, '0, '0, "R10");
        // R4 / R2 / R3: plain writes of several patterns
        step(OFFS, 1, 32'hFFFF_FFFF, '0, '0, "R4");
        step(OFFS, 1, 32'hA5A5_5A5A, '0, '0, "R4");
        step(OFFS, 0, 32'h0000_0000, '0, '0, "R3");
        step(OFFS, 1, 32'h8000_0001, '0, '0, "R2");
        step(OFFS, 1, 32'hFFFF_FFFF, '0, '0, "R4");
        // R5: writes and reads at neighbouring offsets
        step(8'h2C, 1, 32'h0, '0, '0, "R5");
        step(8'h34, 1, 32'h1234_5678, '0, '0, "R5");
        step(8'hB0, 1, 32'h0, '0, '0, "R5");
        step(OFFS, 0, 32'h0, '0, '0, "R5");
        // R6: pulse on bit 5 for three cycles, then on bit 31 back to back
        step(OFFS, 1, 32'hFFFF_FFDF, '0, '0, "R6");
        step(OFFS, 0, 32'h0, '0, '0, "R6");
        step(OFFS, 0, 32'h0, '0, '0, "R6");
        step(OFFS, 1, 32'hFFFF_FFFF, '0, '0, "R6");
        step(OFFS, 1, 32'h7FFF_FFFF, '0, '0, "R6");
        step(OFFS, 1, 32'hFFFF_FFFF, '0, '0, "R6");
        // R7: sequencer clear without a bus write
        step(8'h00, 0, 32'h0, 32'h0000_F00F, '0, "R7");
        step(8'h00, 0, 32'h0, 32'h8000_0001, '0, "R7");
        step(OFFS, 0, 32'h0, '0, '0, "R7");
        // R8: sequencer set
        step(8'h00, 0, 32'h0, '0, 32'h0000_F00F, "R8");
        step(OFFS, 0, 32'h0, '0, 32'h8000_0000, "R8");
        // R9: merge with bus write, clear over set
        step(OFFS, 1, 32'h0000_0000, 32'h0000_000F, 32'h0000_00FF, "R9");
        step(OFFS, 1, 32'hFFFF_0000, 32'h00FF_0000, 32'h0000_F000, "R9");
        step(OFFS, 1, 32'h5555_5555, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
        step(8'h34, 1, 32'hFFFF_FFFF, '0, 32'h0000_0003, "R9");
        step(OFFS, 0, 32'h0, '0, '0, "R10");
        step(OFFS, 0, 32'h0, '0, '0, "R10");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
      end
      begin
        repeat (10000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule